// File: doc/BRIEF.md
# Communication Controller Event Flags and Interrupt Request

This block holds the event state of a serial link controller that runs either a LIN-style frame protocol or a plain UART. Four sticky flags record an error, a finished identifier phase, a finished transmit response and a finished receive response. In slave operation the identifier flag means an identifier arrived. In master operation it means the header went out. A separate error-detail register records which kind of error occurred, one bit per hardware strobe.

Software reaches the block through a small synchronous register port. Writes land on the clock edge, and read data is a combinational function of the address. Flags are cleared by writing a one to their position. In UART mode, accesses to the data register, signalled to this block by strobes, also clear flags. A four-bit enable register masks each flag, and a registered interrupt request goes high while any enabled flag is set.

Top module: `lin_evt_regs`

## Requirements
- R1: While the asynchronous active-low reset is asserted, every flag, every error-detail bit, every enable bit and the interrupt output read as zero.
- R2: In the status register (address 0), bit 0 is receive done, bit 1 is transmit done, bit 2 is identifier done and bit 3 is error. Bits 7:4 always read zero. An event pulse on a clock edge makes its flag read one after that edge.
- R3: A write to address 0 clears each flag whose bit in the write data is one. Flags written with zero keep their value.
- R4: Any clear of the error flag, whether by write-one or by a UART data read, resets every error-detail bit. An error strobe that arrives in the same cycle is still recorded.
- R5: With the UART mode input high, a data-register read strobe clears the error and receive-done flags. With the mode input low, the strobe has no effect.
- R6: With the UART mode input high, a data-register write strobe clears only the transmit-done flag.
- R7: The enable register (address 1) holds write data bits 3:0 with the same bit layout as the status register. Bits 7:4 read zero and ignore written values.
- R8: The interrupt output is one exactly one clock after a cycle in which some flag and its enable bit are both one, and it is zero otherwise.
- R9: When a set event and a clear hit the same flag in one cycle, the flag ends up set.
- R10: Error-detail bit i (address 2) is set by error strobe i, and any error strobe sets the error flag. Bus writes to address 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_mode_i | input | 1 | High selects UART mode side-effect clears |
| bus_addr_i | input | ADDR_W | Register address: 0 status, 1 enable, 2 error detail |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | DATA_W | Register write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i |
| dat_rd_stb_i | input | 1 | Data-register read occurred |
| dat_wr_stb_i | input | 1 | Data-register write occurred |
| id_done_evt_i | input | 1 | Identifier phase finished pulse |
| tx_done_evt_i | input | 1 | Transmit response finished pulse |
| rx_done_evt_i | input | 1 | Receive response finished pulse |
| err_evt_i | input | ERR_W | One strobe per error kind |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench drives a clear into a flag in the same cycle as its set event. A design that gives priority to the clear would drop the event and show a zero flag. It clears the error flag while a fresh error strobe fires, so a design that wipes the detail register after merging the strobe would lose the new detail bit. It issues data-register strobes with the mode input low and then high, and it writes zero and reserved high bits. A design that applies the UART clears in frame mode, or that clears on a zero write, or that stores the reserved enable bits, shows the wrong read-back value. The interrupt is sampled one and two cycles after a flag rises and after the mask changes, which catches an output that is not registered or that ignores the mask.

// File: rtl/lin_evt_pkg.sv
package lin_evt_pkg;
  localparam int NFLAG  = 4;
  localparam int F_RX   = 0;
  localparam int F_TX   = 1;
  localparam int F_ID   = 2;
  localparam int F_ERR  = 3;

  // Flags hit by a write-one-to-clear access
  function automatic logic [NFLAG-1:0] w1c_mask(input logic hit,
                                                input logic [NFLAG-1:0] bits);
    return bits & {NFLAG{hit}};
  endfunction

  // Interrupt request from flags and mask
  function automatic logic irq_any(input logic [NFLAG-1:0] flags,
                                   input logic [NFLAG-1:0] en);
    return |(flags & en);
  endfunction
endpackage

// File: rtl/lin_evt_flag.sv
module lin_evt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  // R3
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/lin_evt_errdet.sv
module lin_evt_errdet #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] strobe_i,
  input  logic             wipe_i,
  output logic [ERR_W-1:0] det_o,
  output logic             any_o
);
  logic [ERR_W-1:0] det_base;

  assign det_base = wipe_i ? '0 : det_o;
  assign any_o    = |strobe_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) det_o <= '0;
    else        det_o <= det_base | strobe_i;
  end

  // R4
  wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe_i && strobe_i == '0) |=> det_o == '0);
  // R10
  record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i != '0) |=> ((det_o & $past(strobe_i)) == $past(strobe_i)));
endmodule

// File: rtl/lin_evt_irq.sv
module lin_evt_irq
  import lin_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr_i,
  input  logic [NFLAG-1:0] en_wdata_i,
  input  logic [NFLAG-1:0] flags_i,
  output logic [NFLAG-1:0] en_o,
  output logic             irq_o
);
  logic irq_next;

  assign irq_next = irq_any(flags_i, en_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o  <= '0;
      irq_o <= 1'b0;
    end else begin
      if (en_wr_i) en_o <= en_wdata_i;
      irq_o <= irq_next;
    end
  end

  // R8
  irq_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_i & en_o) != '0) |=> irq_o);
  // R8
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_i & en_o) == '0) |=> !irq_o);
endmodule

// File: rtl/lin_evt_regs.sv
module lin_evt_regs
  import lin_evt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uart_mode_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              dat_rd_stb_i,
  input  logic              dat_wr_stb_i,
  input  logic              id_done_evt_i,
  input  logic              tx_done_evt_i,
  input  logic              rx_done_evt_i,
  input  logic [ERR_W-1:0]  err_evt_i,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DET  = ADDR_W'(2);

  logic [NFLAG-1:0] flag_set, flag_clr, sw_clr, flags, en;
  logic [ERR_W-1:0] det;
  logic             any_err, uart_rd, uart_wr, stat_wr, en_wr;
  logic [DATA_W-1:0] det_ext;

  assign stat_wr = bus_wr_i && (bus_addr_i == A_STAT);
  assign en_wr   = bus_wr_i && (bus_addr_i == A_EN);
  assign uart_rd = uart_mode_i && dat_rd_stb_i;
  assign uart_wr = uart_mode_i && dat_wr_stb_i;
  assign sw_clr  = w1c_mask(stat_wr, bus_wdata_i[NFLAG-1:0]);

  always_comb begin
    flag_set        = '0;
    flag_set[F_RX]  = rx_done_evt_i;
    flag_set[F_TX]  = tx_done_evt_i;
    flag_set[F_ID]  = id_done_evt_i;
    flag_set[F_ERR] = any_err;
    flag_clr        = sw_clr;
    flag_clr[F_RX]  = sw_clr[F_RX]  | uart_rd;
    flag_clr[F_ERR] = sw_clr[F_ERR] | uart_rd;
    flag_clr[F_TX]  = sw_clr[F_TX]  | uart_wr;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    lin_evt_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set[i]),
      .clr_i (flag_clr[i]),
      .q_o   (flags[i])
    );
  end

  lin_evt_errdet #(.ERR_W(ERR_W)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (err_evt_i),
    .wipe_i   (flag_clr[F_ERR]),
    .det_o    (det),
    .any_o    (any_err)
  );

  lin_evt_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_wr_i    (en_wr),
    .en_wdata_i (bus_wdata_i[NFLAG-1:0]),
    .flags_i    (flags),
    .en_o       (en),
    .irq_o      (irq_o)
  );

  always_comb begin
    det_ext = '0;
    det_ext[ERR_W-1:0] = det;
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_STAT:  bus_rdata_o[NFLAG-1:0] = flags;
      A_EN:    bus_rdata_o[NFLAG-1:0] = en;
      A_DET:   bus_rdata_o = det_ext;
      default: bus_rdata_o = '0;
    endcase
  end

  // R5
  uart_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_rd && !any_err && !rx_done_evt_i) |=> (!flags[F_ERR] && !flags[F_RX]));
  // R5
  lin_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uart_mode_i && !bus_wr_i && flags[F_RX] && flags[F_ERR]) |=> (flags[F_RX] && flags[F_ERR]));
  // R6
  uart_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_wr && !tx_done_evt_i) |=> !flags[F_TX]);
  // R7
  en_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && bus_wdata_i[DATA_W-1:NFLAG] != '0) |=> en == $past(bus_wdata_i[NFLAG-1:0]));
  // R10
  det_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == A_DET && err_evt_i == '0 && !flag_clr[F_ERR]) |=> $stable(det));
endmodule

// File: tb/tb_lin_evt_regs.sv
`timescale 1ns/100ps
module tb_lin_evt_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       uart_mode = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       drd = 1'b0, dwr = 1'b0;
  logic       id_evt = 1'b0, tx_evt = 1'b0, rx_evt = 1'b0;
  logic [7:0] err_evt = 8'h00;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lin_evt_regs dut (
    .clk(clk), .rst_n(rst_n), .uart_mode_i(uart_mode),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .dat_rd_stb_i(drd), .dat_wr_stb_i(dwr),
    .id_done_evt_i(id_evt), .tx_done_evt_i(tx_evt), .rx_done_evt_i(rx_evt),
    .err_evt_i(err_evt), .irq_o(irq)
  );

  // {uart,drd,dwr,wr, wdata, id,tx,rx, err, exp_stat, exp_det}
  typedef struct packed {
    logic       uart, drd, dwr, wr;
    logic [7:0] wd;
    logic       id, tx, rx;
    logic [7:0] err;
    logic [3:0] es;
    logic [7:0] ed;
  } vec_t;

  localparam logic [36:0] VECS [0:12] = '{
    {4'b0000, 8'h00, 3'b100, 8'h00, 4'b0100, 8'h00}, // R2 id set
    {4'b0000, 8'h00, 3'b000, 8'h05, 4'b1100, 8'h05}, // R10 strobes set err
    {4'b0000, 8'h00, 3'b011, 8'h00, 4'b1111, 8'h05}, // R2 tx, rx
    {4'b0001, 8'h02, 3'b000, 8'h00, 4'b1101, 8'h05}, // R3 w1c tx
    {4'b0001, 8'h00, 3'b000, 8'h00, 4'b1101, 8'h05}, // R3 zero write
    {4'b0100, 8'h00, 3'b000, 8'h00, 4'b1101, 8'h05}, // R5 frame mode read
    {4'b1100, 8'h00, 3'b000, 8'h00, 4'b0100, 8'h00}, // R5 R4 uart read
    {4'b0000, 8'h00, 3'b010, 8'h80, 4'b1110, 8'h80}, // R10
    {4'b1010, 8'h00, 3'b000, 8'h00, 4'b1100, 8'h80}, // R6 uart write
    {4'b0001, 8'h08, 3'b000, 8'h02, 4'b1100, 8'h02}, // R9 R4 clear vs strobe
    {4'b0001, 8'h0C, 3'b000, 8'h00, 4'b0000, 8'h00}, // R4 clear err + id
    {4'b1100, 8'h00, 3'b001, 8'h00, 4'b0001, 8'h00}, // R9 rx set vs uart read
    {4'b0001, 8'hF1, 3'b000, 8'h00, 4'b0000, 8'h00}  // R3 high bits ignored
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic idle_inputs();
    uart_mode = 1'b0; drd = 1'b0; dwr = 1'b0; wr = 1'b0; wdata = 8'h00;
    id_evt = 1'b0; tx_evt = 1'b0; rx_evt = 1'b0; err_evt = 8'h00;
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    vec_t v;
    // R1 reset state
    tick(); tick();
    rd(2'd0, d); chk("R1 status", d, 8'h00);
    rd(2'd1, d); chk("R1 enable", d, 8'h00);
    rd(2'd2, d); chk("R1 detail", d, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 13; i++) begin
      v = VECS[i];
      uart_mode = v.uart; drd = v.drd; dwr = v.dwr; wr = v.wr; wdata = v.wd;
      addr = 2'd0; id_evt = v.id; tx_evt = v.tx; rx_evt = v.rx; err_evt = v.err;
      tick();
      idle_inputs();
      rd(2'd0, d); chk($sformatf("R2/R3/R5/R6/R9 vec %0d status", i), d, {4'h0, v.es});
      rd(2'd2, d); chk($sformatf("R4/R10 vec %0d detail", i), d, v.ed);
    end
    chk("R8 irq masked during table", {7'd0, irq}, 8'h00);

    // R7 enable register, reserved bits
    @(negedge clk);
    bus_write(2'd1, 8'hFA);
    rd(2'd1, d); chk("R7 enable readback", d, 8'h0A);
    @(negedge clk);
    bus_write(2'd1, 8'h0F);
    rd(2'd1, d); chk("R7 enable all", d, 8'h0F);

    // R8 interrupt latency (flag 0001 present from table? cleared: stat 0000)
    @(negedge clk);
    tx_evt = 1'b1;
    tick();
    tx_evt = 1'b0;
    chk("R8 irq one cycle after flag", {7'd0, irq}, 8'h00);
    tick();
    chk("R8 irq two cycles after event", {7'd0, irq}, 8'h01);

    // R8 mask transmit done (bit 1)
    bus_write(2'd1, 8'h0D);
    chk("R8 irq still high right after mask", {7'd0, irq}, 8'h01);
    tick();
    chk("R8 irq low after mask", {7'd0, irq}, 8'h00);
    bus_write(2'd1, 8'h02);
    tick();
    chk("R8 irq back with enable", {7'd0, irq}, 8'h01);

    // R10 detail register not writable
    err_evt = 8'h10;
    tick();
    err_evt = 8'h00;
    bus_write(2'd2, 8'hFF);
    rd(2'd2, d); chk("R10 detail write ignored", d, 8'h10);
    rd(2'd0, d); chk("R10 err flag from strobe", d, 8'h0A);

    // R4 clear err by W1C wipes detail
    @(negedge clk);
    bus_write(2'd0, 8'h08);
    rd(2'd2, d); chk("R4 detail wiped", d, 8'h00);
    rd(2'd0, d); chk("R3 only err cleared", d, 8'h02);

    // R1 asynchronous reset mid-run
    @(negedge clk);
    rx_evt = 1'b1; id_evt = 1'b1; err_evt = 8'h03;
    tick();
    idle_inputs();
    #0.5;
    rst_n = 1'b0;
    #0.5;
    rd(2'd0, d); chk("R1 status after reset", d, 8'h00);
    rd(2'd1, d); chk("R1 enable after reset", d, 8'h00);
    rd(2'd2, d); chk("R1 detail after reset", d, 8'h00);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule